// File: doc/BRIEF.md
# HDLC LAPD Message Receiver

This block pulls a LAPD data-link message out of a serial overhead channel. The channel carries one message bit per inbound E3 frame, so a bit is only taken when a per-frame valid strobe is high. The receiver hunts for the 0x7E flag, removes stuffed zeros, assembles octets least significant bit first and runs the 16-bit CCITT CRC over everything between the flags.

Octets are numbered from 0 after the opening flag. Octets 0 and 1 are the address and octet 2 is control. The last two octets before the closing flag are the FCS. Every octet in between is information. Information octets go out on a byte write port into a fixed 88-byte buffer window starting at byte address 0xDE.

When a message completes, the block updates a sticky status byte and pulses an interrupt request. Message end, FCS error, abort, flag, overflow, the C/R bit and a decoded message type are all reported there. A read strobe clears the sticky bits.

Top module: `lapd_rx`

## Requirements
- R1: A bit is consumed only in a clock cycle with `bit_vld_i` high. `bit_i` is ignored in every other cycle.
- R2: Each received flag (raw bits 0,1,1,1,1,1,1,0) sets `stat_o[1]`.
- R3: Between flags, a 0 that follows five consecutive 1s is removed before octet assembly, and octets are built least significant bit first.
- R4: Information octets (octet 3 up to, but not including, the two FCS octets) are written in order, one `wr_en_o` pulse each, to `wr_addr_o` = 0xDE + n for the n-th information octet.
- R5: At the closing flag, `stat_o[3]` is set when the CRC residue (x^16+x^12+x^5+1, preset all ones, LSB first) over all octets including the FCS is not 0xF0B8.
- R6: A closing flag that ends a message of at least 5 octets, on an octet boundary, sets `stat_o[0]` and raises `irq_o` for exactly one clock.
- R7: Seven consecutive 1s inside a message abort it. The abort sets `stat_o[2]`, sets neither `stat_o[0]` nor `irq_o`, and leaves the receiver hunting for a flag.
- R8: At message end, `stat_o[4]` takes bit 1 of address octet 0.
- R9: At message end, `stat_o[7:6]` gives the type of the first information octet: 0x38→1, 0x34→2, 0x32→3, any other value or no information octet→0.
- R10: Information octets beyond 88 are not written, and each one sets `stat_o[5]`. The address never wraps.
- R11: `stat_o[5:0]` except bit 4 are sticky until a cycle with `stat_rd_i` high clears them. A set in the same cycle wins. Bits 4 and 7:6 hold until the next message end. All bits reset to 0.
- R12: While `en_i` is low the receiver is idle and makes no write, status event or interrupt. After `en_i` rises, nothing is received before a flag.
- R13: A closing flag after fewer than 5 octets, or not on an octet boundary, ends nothing. No status other than `stat_o[1]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| bit_vld_i | input | 1 | Per-frame strobe qualifying `bit_i` |
| bit_i | input | 1 | Serial message bit |
| stat_rd_i | input | 1 | Status read strobe, clears sticky bits |
| wr_en_o | output | 1 | Buffer byte write strobe |
| wr_addr_o | output | ADDR_W | Buffer byte address |
| wr_data_o | output | 8 | Buffer byte data |
| stat_o | output | 8 | {type[1:0], overflow, C/R, FCS error, abort, flag, end of message} |
| irq_o | output | 1 | One-clock pulse at end of message |

## Verification
Status bits and `irq_o` are registered from the cycle that samples the last bit of the closing flag or the abort, so they are due one edge later. The bench waits several negative edges after that bit before it reads `stat_o`. The write for an information octet can only be issued after six more accepted bits, because the destuffer hides the newest six and a further two octets must arrive. For that reason the bench logs every write at falling edges throughout the message and compares the log only after the closing flag. `irq_o` is counted at every falling edge, which checks its one-cycle width independently of when it occurs.

// File: rtl/lapd_pkg.sv
package lapd_pkg;
  localparam int unsigned DLY_BITS = 6;   // bits a flag contributes before it is recognised
  localparam logic [15:0] CRC_GOOD = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;

  typedef enum logic [1:0] {MT_OTHER = 2'd0, MT_PATH = 2'd1, MT_IDLE = 2'd2, MT_TEST = 2'd3} msg_type_e;

  typedef struct packed {
    logic eom;
    logic flag;
    logic abort;
    logic fcs_err;
    logic ovf;
  } evt_t;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    logic [15:0] n;
    n = {1'b0, c[15:1]};
    if (c[0] ^ b) n = n ^ CRC_POLY_R;
    return n;
  endfunction

  function automatic msg_type_e decode_type(logic [7:0] o);
    case (o)
      8'h38:   return MT_PATH;
      8'h34:   return MT_IDLE;
      8'h32:   return MT_TEST;
      default: return MT_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/lapd_destuff.sv
module lapd_destuff
  import lapd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic vld_i,
  input  logic bit_i,
  output logic commit_o,
  output logic cbit_o,
  output logic flag_o,
  output logic abort_o
);
  localparam int unsigned FILL_W = $clog2(DLY_BITS + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DLY_BITS);

  logic [2:0]          ones_q;
  logic [DLY_BITS-1:0] dl_q;
  logic [FILL_W-1:0]   fill_q;
  logic take, stuffed, held, acc;

  always_comb begin
    take     = en_i & vld_i;
    flag_o   = take & ~bit_i & (ones_q == 3'd6);
    abort_o  = take & bit_i & (ones_q >= 3'd6);
    stuffed  = ~bit_i & (ones_q == 3'd5);
    held     = bit_i & (ones_q == 3'd5);  // sixth one: flag or abort, never data
    acc      = take & ~flag_o & ~abort_o & ~stuffed & ~held;
    commit_o = acc & (fill_q == FILL_MAX);
    cbit_o   = dl_q[DLY_BITS-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
      dl_q   <= '0;
      fill_q <= '0;
    end else if (!en_i) begin
      ones_q <= '0;
      dl_q   <= '0;
      fill_q <= '0;
    end else if (take) begin
      if (bit_i) ones_q <= (ones_q == 3'd7) ? ones_q : ones_q + 3'd1;
      else       ones_q <= '0;
      if (flag_o || abort_o) begin
        fill_q <= '0;
      end else if (acc) begin
        dl_q   <= {dl_q[DLY_BITS-2:0], bit_i};
        fill_q <= (fill_q == FILL_MAX) ? fill_q : fill_q + FILL_W'(1);
      end
    end
  end
endmodule

// File: rtl/lapd_octet.sv
module lapd_octet
  import lapd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned BUF_BASE  = 222,
  parameter int unsigned BUF_DEPTH = 88
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              commit_i,
  input  logic              cbit_i,
  input  logic              flag_i,
  input  logic              abort_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output evt_t              evt_o,
  output logic              cr_o,
  output msg_type_e         type_o
);
  localparam int unsigned HDR_OCT = 3;
  localparam int unsigned FCS_OCT = 2;
  localparam int unsigned MIN_OCT = HDR_OCT + FCS_OCT;
  localparam int unsigned CNT_W   = $clog2(BUF_DEPTH + MIN_OCT + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_OCT);

  logic              in_frame_q;
  logic [2:0]        bitcnt_q;
  logic [7:0]        sr_q, pn_q, po_q, ty_q;
  logic [15:0]       crc_q;
  logic [CNT_W-1:0]  cnt_q, idx;
  logic              cr_q;
  logic              byte_done, info_ok, in_win, good_len, eom;
  logic [7:0]        byte_w;

  always_comb begin
    byte_done = commit_i & in_frame_q & (bitcnt_q == 3'd7);
    byte_w    = {cbit_i, sr_q[7:1]};
    // octet k completing releases octet k-2 as information
    info_ok   = byte_done & (cnt_q >= CNT_MIN);
    idx       = cnt_q - CNT_MIN;
    in_win    = idx < CNT_W'(BUF_DEPTH);
    good_len  = (bitcnt_q == 3'd0) & (cnt_q >= CNT_MIN);
    eom       = flag_i & in_frame_q & good_len;

    evt_o.eom     = eom;
    evt_o.flag    = flag_i;
    evt_o.abort   = abort_i & in_frame_q;
    evt_o.fcs_err = eom & (crc_q != CRC_GOOD);
    evt_o.ovf     = info_ok & ~in_win;
    cr_o          = cr_q;
    type_o        = (cnt_q > CNT_MIN) ? decode_type(ty_q) : MT_OTHER;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      bitcnt_q   <= '0;
      sr_q       <= '0;
      crc_q      <= '1;
      cnt_q      <= '0;
      pn_q       <= '0;
      po_q       <= '0;
      ty_q       <= '0;
      cr_q       <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (!en_i) begin
        in_frame_q <= 1'b0;
        bitcnt_q   <= '0;
        cnt_q      <= '0;
      end else if (flag_i) begin
        in_frame_q <= 1'b1;
        bitcnt_q   <= '0;
        crc_q      <= '1;
        cnt_q      <= '0;
      end else if (abort_i) begin
        in_frame_q <= 1'b0;
      end else if (commit_i && in_frame_q) begin
        bitcnt_q <= bitcnt_q + 3'd1;
        sr_q     <= byte_w;
        crc_q    <= crc_step(crc_q, cbit_i);
        if (byte_done) begin
          cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
          pn_q  <= byte_w;
          po_q  <= pn_q;
          if (cnt_q == '0) cr_q <= byte_w[1];
          if (cnt_q == CNT_MIN) ty_q <= po_q;
          if (info_ok && in_win) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= ADDR_W'(BUF_BASE) + ADDR_W'(idx);
            wr_data_o <= po_q;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lapd_status.sv
module lapd_status
  import lapd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  evt_t      evt_i,
  input  logic      cr_i,
  input  msg_type_e type_i,
  input  logic      rd_i,
  output logic [7:0] stat_o,
  output logic      irq_o
);
  evt_t      st_q;
  logic      cr_q;
  msg_type_e ty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      cr_q  <= 1'b0;
      ty_q  <= MT_OTHER;
      irq_o <= 1'b0;
    end else begin
      st_q  <= (rd_i ? evt_t'('0) : st_q) | evt_i;  // set beats clear
      irq_o <= evt_i.eom;
      if (evt_i.eom) begin
        cr_q <= cr_i;
        ty_q <= type_i;
      end
    end
  end

  assign stat_o = {ty_q, st_q.ovf, cr_q, st_q.fcs_err, st_q.abort, st_q.flag, st_q.eom};
endmodule

// File: rtl/lapd_rx.sv
module lapd_rx
  import lapd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned BUF_BASE  = 222,
  parameter int unsigned BUF_DEPTH = 88
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              stat_rd_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [7:0]        stat_o,
  output logic              irq_o
);
  logic      commit, cbit, flag, abort, cr;
  evt_t      evt;
  msg_type_e mtype;

  lapd_destuff u_destuff (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .vld_i    (bit_vld_i),
    .bit_i    (bit_i),
    .commit_o (commit),
    .cbit_o   (cbit),
    .flag_o   (flag),
    .abort_o  (abort)
  );

  lapd_octet #(
    .ADDR_W    (ADDR_W),
    .BUF_BASE  (BUF_BASE),
    .BUF_DEPTH (BUF_DEPTH)
  ) u_octet (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .commit_i  (commit),
    .cbit_i    (cbit),
    .flag_i    (flag),
    .abort_i   (abort),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .evt_o     (evt),
    .cr_o      (cr),
    .type_o    (mtype)
  );

  lapd_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .cr_i   (cr),
    .type_i (mtype),
    .rd_i   (stat_rd_i),
    .stat_o (stat_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/lapd_rx_chk.sv
module lapd_rx_chk #(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned BUF_BASE  = 222,
  parameter int unsigned BUF_DEPTH = 88
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              bit_vld_i,
  input logic              stat_rd_i,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [7:0]        stat_o,
  input logic              irq_o
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(BUF_BASE);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(BUF_BASE + BUF_DEPTH);

  // R4
  wr_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o >= LO && wr_addr_o < HI));
  // R6
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R6
  irq_eom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat_o[0]);
  // R12
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!wr_en_o && !irq_o));
  // R1
  no_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> (!wr_en_o && !irq_o));
  // R11
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> (stat_o[0] == irq_o));
  // R7
  abort_no_eom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[2]) |-> !irq_o);
endmodule

bind lapd_rx lapd_rx_chk #(
  .ADDR_W    (ADDR_W),
  .BUF_BASE  (BUF_BASE),
  .BUF_DEPTH (BUF_DEPTH)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .bit_vld_i (bit_vld_i),
  .stat_rd_i (stat_rd_i),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .stat_o    (stat_o),
  .irq_o     (irq_o)
);

// File: tb/lapd_rx_tb.sv
module lapd_rx_tb;
  localparam int BASE  = 222;
  localparam int DEPTH = 88;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, vld = 1'b0, din = 1'b0, rd = 1'b0;
  logic       wr_en, irq;
  logic [8:0] wr_addr;
  logic [7:0] wr_data, stat;

  int checks = 0, errors = 0, irq_cnt = 0, gap_max = 2;
  logic [7:0] wlog[$];
  logic [8:0] alog[$];

  always #2 clk = ~clk;

  lapd_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bit_vld_i(vld), .bit_i(din),
    .stat_rd_i(rd), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .stat_o(stat), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      wlog.push_back(wr_data);
      alog.push_back(wr_addr);
    end
    if (irq) irq_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // R1: din is scrambled while vld is low
  task automatic send_bit(input bit b);
    vld = 1'b1; din = b;
    @(negedge clk);
    vld = 1'b0; din = 1'($urandom_range(0, 1));
    repeat ($urandom_range(0, gap_max)) @(negedge clk);
  endtask

  task automatic send_flag();
    send_bit(0);
    repeat (6) send_bit(1);
    send_bit(0);
  endtask

  task automatic send_byte(input logic [7:0] v, inout int ones);
    for (int i = 0; i < 8; i++) begin
      send_bit(v[i]);
      if (v[i]) ones++; else ones = 0;
      if (ones == 5) begin
        send_bit(0);
        ones = 0;
      end
    end
  endtask

  function automatic logic [15:0] crc16(input logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[k]) for (int i = 0; i < 8; i++) begin
      logic fb = c[0] ^ q[k][i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  function automatic int exp_type(input logic [7:0] info[$]);
    if (info.size() == 0) return 0;
    case (info[0])
      8'h38: return 1;
      8'h34: return 2;
      8'h32: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic send_frame(input logic [7:0] body[$], input bit bad);
    logic [15:0] fcs;
    int ones = 0;
    fcs = ~crc16(body);
    if (bad) fcs[0] = ~fcs[0];
    send_flag();
    foreach (body[k]) send_byte(body[k], ones);
    send_byte(fcs[7:0], ones);
    send_byte(fcs[15:8], ones);
    send_flag();
  endtask

  task automatic pulse_rd();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] a0, input logic [7:0] info[$], input bit bad);
    logic [7:0] body[$];
    int nwr, mism;
    logic [7:0] held;
    body = {a0, 8'h01, 8'h03};
    foreach (info[k]) body.push_back(info[k]);
    wlog.delete(); alog.delete(); irq_cnt = 0;
    send_frame(body, bad);
    repeat (3) @(negedge clk);
    nwr = (info.size() > DEPTH) ? DEPTH : info.size();
    chk(stat[0] == 1'b1, "R6 eom", stat[0], 1);
    chk(irq_cnt == 1, "R6 irq pulses", irq_cnt, 1);
    chk(stat[1] == 1'b1, "R2 flag", stat[1], 1);
    chk(stat[3] == bad, "R5 fcs", stat[3], bad);
    chk(stat[4] == a0[1], "R8 cr", stat[4], a0[1]);
    chk(int'(stat[7:6]) == exp_type(info), "R9 type", stat[7:6], exp_type(info));
    chk(stat[5] == (info.size() > DEPTH), "R10 ovf", stat[5], info.size() > DEPTH);
    chk(stat[2] == 1'b0, "R7 no abort", stat[2], 0);
    chk(wlog.size() == nwr, "R4 write count", wlog.size(), nwr);
    mism = 0;
    for (int i = 0; i < wlog.size() && i < nwr; i++)
      if (wlog[i] !== info[i] || alog[i] !== 9'(BASE + i)) mism++;
    chk(mism == 0, "R3 R4 write data/address", mism, 0);
    repeat (5) @(negedge clk);
    chk(stat[0] == 1'b1, "R11 sticky", stat[0], 1);
    held = stat;
    pulse_rd();
    chk((stat & 8'h2F) == 8'h00, "R11 clear", stat & 8'h2F, 0);
    chk(stat[7:6] == held[7:6] && stat[4] == held[4], "R11 held fields", stat, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] info[$];
    logic [7:0] body[$];
    int ones;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat == 8'h00 && !wr_en && !irq, "R11 reset", stat, 0);

    // R12: disabled receiver ignores a complete frame
    wlog.delete(); irq_cnt = 0;
    body = {8'h02, 8'h01, 8'h03, 8'h38, 8'h55};
    send_frame(body, 1'b0);
    repeat (3) @(negedge clk);
    chk(stat == 8'h00 && wlog.size() == 0 && irq_cnt == 0, "R12 disabled", stat, 0);
    en = 1'b1;
    @(negedge clk);

    // R3: stuffing-heavy payload
    info = {8'h38, 8'hFF, 8'hFF, 8'h7E, 8'h3E, 8'h1F, 8'hF8};
    run_frame(8'h02, info, 1'b0);
    // R9: empty information field
    info = {};
    run_frame(8'h00, info, 1'b0);
    // R5: corrupted FCS
    info = {8'h34, 8'hA5, 8'h5A};
    run_frame(8'hFE, info, 1'b1);
    // R1: long gaps with noise between strobes
    gap_max = 6;
    info = {8'h32, 8'h00, 8'hFF, 8'h81};
    run_frame(8'h02, info, 1'b0);
    gap_max = 2;
    // R10: overflow of the buffer window
    info = {};
    for (int i = 0; i < DEPTH + 7; i++) info.push_back(8'(i * 7 + 1));
    run_frame(8'h00, info, 1'b0);

    // R7: abort after header and two octets
    irq_cnt = 0; wlog.delete(); ones = 0;
    send_flag();
    send_byte(8'h02, ones); send_byte(8'h01, ones); send_byte(8'h03, ones);
    send_byte(8'h38, ones); send_byte(8'h11, ones);
    repeat (8) send_bit(1);
    repeat (3) @(negedge clk);
    chk(stat[2] == 1'b1, "R7 abort", stat[2], 1);
    chk(stat[0] == 1'b0 && irq_cnt == 0, "R7 no eom", stat[0], 0);
    pulse_rd();

    // R13: short frame and unaligned frame end nothing
    irq_cnt = 0; ones = 0;
    send_flag();
    send_byte(8'h02, ones); send_byte(8'h01, ones); send_byte(8'h03, ones);
    send_flag();
    for (int i = 0; i < 44; i++) send_bit(i % 3 == 0);
    send_flag();
    repeat (3) @(negedge clk);
    chk(stat[0] == 1'b0 && irq_cnt == 0 && stat[1] == 1'b1, "R13 short/unaligned", stat, 2);
    pulse_rd();

    // random frames
    for (int n = 0; n < 8; n++) begin
      logic [7:0] a0;
      int len = $urandom_range(0, 24);
      info = {};
      for (int i = 0; i < len; i++) begin
        case ($urandom_range(0, 3))
          0: info.push_back(8'hFF);
          1: info.push_back(8'h7E);
          default: info.push_back(8'($urandom));
        endcase
      end
      if (len > 0 && $urandom_range(0, 1)) begin
        case ($urandom_range(0, 2))
          0: info[0] = 8'h38;
          1: info[0] = 8'h34;
          default: info[0] = 8'h32;
        endcase
      end
      a0 = 8'($urandom) & 8'hFE;
      run_frame(a0, info, 1'($urandom_range(0, 1)));
    end
    summary();
  end
endmodule